// File: doc/BRIEF.md
# Video Line Burst Write Controller

This block takes a streaming luma/chroma pixel input (16-bit pixels tagged with frame-start, line-start, line-end and valid markers) and moves it into external memory through a simplified memory-mapped write channel. Each accepted pixel is widened to a 32-bit memory word and placed in a line buffer. When a line-end marker arrives, the block queues one write burst for that line. The channel takes a request carrying a byte address and a beat count. The data beats then follow under valid/ready handshaking, with the final beat flagged.

The burst address comes from a base address input plus the line's index within the frame, scaled by the byte length of a line. The block counts frames and the lines of the current frame. Once the burst for the line at half a tile height has fully left the block, it sends a one-cycle trigger to a downstream reader. The reader can then start fetching the frame while writing is still going on. Buffer full and empty flags are brought out for debug.

Top module: `vid_line_burst_writer`

## Requirements
- R1: After reset, req_valid, wr_valid and rd_start are low, frame_count and line_count are zero, fifo_empty is high and fifo_full is low.
- R2: Each pixel accepted (pix_valid high) leaves as one beat whose bits 15:0 hold the pixel and whose bits 31:16 are zero. Beats leave in arrival order. Cycles with pix_valid low change nothing, whatever the other inputs carry.
- R3: Every accepted line-end marker produces exactly one request with req_len = PIXELS-1 (beat count minus one), followed by exactly PIXELS beats. wr_last is high on the final beat only.
- R4: The request address is base_addr + line_index × PIXELS × 4. line_index is 0 for the line that carries the frame-start marker and rises by one for each later line of the frame.
- R5: A raised request holds req_valid and req_addr unchanged until req_ready is seen. A raised beat holds wr_valid and wr_data unchanged until wr_ready is seen.
- R6: rd_start is high for exactly one cycle, the cycle after the final beat of the line with index TILE_H/2-1 is accepted. It is high at no other time.
- R7: frame_count rises by one for each accepted pixel carrying the frame-start marker. line_count gives the number of line-end markers accepted since the latest frame start, and is cleared by a frame start. A frame-start pixel must also carry the line-start marker.
- R8: The line buffer holds 2×PIXELS words. With the memory side stalled, two complete lines set fifo_full. Once the bursts drain, fifo_empty returns high. A pixel must not be offered while fifo_full is high, and a third line must not end while two bursts are still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 32 | Byte address of line 0 of the frame |
| pix_data | input | 16 | Incoming pixel |
| pix_valid | input | 1 | Pixel qualifier |
| pix_sof | input | 1 | First pixel of a frame |
| pix_sol | input | 1 | First pixel of a line |
| pix_eol | input | 1 | Last pixel of a line |
| req_valid | output | 1 | Burst request pending |
| req_addr | output | 32 | Burst byte address |
| req_len | output | $clog2(PIXELS+1) | Beats in the burst minus one |
| req_ready | input | 1 | Memory accepts the request |
| wr_data | output | 32 | Beat data |
| wr_valid | output | 1 | Beat valid |
| wr_last | output | 1 | Final beat of the burst |
| wr_ready | input | 1 | Memory accepts the beat |
| rd_start | output | 1 | One-cycle trigger for the reader |
| frame_count | output | FRAME_W | Frames started |
| line_count | output | $clog2(LINES+1) | Lines ended in the current frame |
| fifo_full | output | 1 | Line buffer full (debug) |
| fifo_empty | output | 1 | Line buffer empty (debug) |

## Verification
Three whole frames run through the block, each with its own memory behaviour. The first has a memory that is always ready. The second has a slow request grant and a beat acceptance that alternates. The third accepts one beat in three. Together they separate correct holding and ordering from designs that only work when nothing stalls. The idle gaps between lines carry junk data with every marker set, so any pixel taken without pix_valid shows up as a data mismatch. A held-off memory fills the buffer to test the flags and the second pending burst. A final frame after a partial one shows that the line index returns to zero at frame start and that the trigger fires once per frame.

// File: rtl/vlbw_pkg.sv
`timescale 1ns/1ps
package vlbw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_DATA
  } burst_state_t;

  // Widen a 16-bit pixel into a 32-bit memory word, upper half zero.
  function automatic logic [31:0] pad_pixel(input logic [15:0] pix);
    return {16'h0000, pix};
  endfunction

  // Byte address of a line: base plus index times line length in bytes.
  function automatic logic [31:0] line_address(input logic [31:0] base,
                                               input logic [31:0] line,
                                               input int unsigned pixels);
    return base + line * (32'(pixels) * 32'd4);
  endfunction

endpackage

// File: rtl/vlbw_fifo.sv
`timescale 1ns/1ps
module vlbw_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign pop_data = mem[rd_ptr];
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);

  // R8: the producer never pushes into a full buffer
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8: the burst engine never pops an empty buffer
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/vlbw_burst_engine.sv
`timescale 1ns/1ps
module vlbw_burst_engine
  import vlbw_pkg::*;
#(
  parameter int PIXELS = 640,
  parameter int LINE_W = 9,
  parameter int LEN_W  = 10,
  parameter int TILE_H = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_done,
  input  logic [LINE_W-1:0] line_idx,
  input  logic [31:0]       line_addr,
  input  logic              fifo_empty,
  input  logic [31:0]       fifo_data,
  output logic              fifo_pop,
  output logic              req_valid,
  output logic [31:0]       req_addr,
  output logic [LEN_W-1:0]  req_len,
  input  logic              req_ready,
  output logic [31:0]       wr_data,
  output logic              wr_valid,
  output logic              wr_last,
  input  logic              wr_ready,
  output logic              rd_start
);
  localparam int BW   = $clog2(PIXELS + 1);
  localparam int HALF = TILE_H / 2;

  burst_state_t      state;
  logic [31:0]       cur_addr, pend_addr;
  logic [LINE_W-1:0] cur_line, pend_line;
  logic              pend_valid;
  logic [BW-1:0]     beat_cnt;

  // Named internal events
  logic req_fire, beat_fire, last_fire, trigger_line;
  assign req_fire     = (state == ST_REQ) && req_ready;
  assign beat_fire    = (state == ST_DATA) && !fifo_empty && wr_ready;
  assign last_fire    = beat_fire && (beat_cnt == BW'(PIXELS - 1));
  assign trigger_line = (cur_line == LINE_W'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_addr   <= '0;
      cur_line   <= '0;
      pend_addr  <= '0;
      pend_line  <= '0;
      pend_valid <= 1'b0;
      beat_cnt   <= '0;
      rd_start   <= 1'b0;
    end else begin
      rd_start <= last_fire && trigger_line;
      case (state)
        ST_IDLE: begin
          if (line_done) begin
            cur_addr <= line_addr;
            cur_line <= line_idx;
            state    <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (req_fire) begin
            beat_cnt <= '0;
            state    <= ST_DATA;
          end
        end
        default: begin
          if (beat_fire) beat_cnt <= beat_cnt + 1'b1;
        end
      endcase

      if (last_fire) begin
        if (pend_valid) begin
          cur_addr   <= pend_addr;
          cur_line   <= pend_line;
          state      <= ST_REQ;
          pend_valid <= line_done;
          if (line_done) begin
            pend_addr <= line_addr;
            pend_line <= line_idx;
          end
        end else if (line_done) begin
          cur_addr <= line_addr;
          cur_line <= line_idx;
          state    <= ST_REQ;
        end else begin
          state <= ST_IDLE;
        end
      end else if (line_done && state != ST_IDLE) begin
        pend_addr  <= line_addr;
        pend_line  <= line_idx;
        pend_valid <= 1'b1;
      end
    end
  end

  assign req_valid = (state == ST_REQ);
  assign req_addr  = cur_addr;
  assign req_len   = LEN_W'(PIXELS - 1);
  assign wr_valid  = (state == ST_DATA) && !fifo_empty;
  assign wr_data   = fifo_data;
  assign wr_last   = wr_valid && (beat_cnt == BW'(PIXELS - 1));
  assign fifo_pop  = beat_fire;

  // R5: a request waits unchanged for its grant
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));
  // R5: a beat waits unchanged for acceptance
  p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
  // R3: the last flag only marks a live beat
  p_last_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |-> wr_valid);
  // R6: the reader trigger never stretches past one cycle
  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);
  // R8: the single pending slot is only refilled as it drains
  p_pend_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && pend_valid) |-> last_fire);

endmodule

// File: rtl/vid_line_burst_writer.sv
`timescale 1ns/1ps
module vid_line_burst_writer
  import vlbw_pkg::*;
#(
  parameter int PIXELS  = 640,
  parameter int LINES   = 480,
  parameter int TILE_H  = 60,
  parameter int FRAME_W = 16,
  localparam int LINE_W = $clog2(LINES + 1),
  localparam int LEN_W  = $clog2(PIXELS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        base_addr,
  input  logic [15:0]        pix_data,
  input  logic               pix_valid,
  input  logic               pix_sof,
  input  logic               pix_sol,
  input  logic               pix_eol,
  output logic               req_valid,
  output logic [31:0]        req_addr,
  output logic [LEN_W-1:0]   req_len,
  input  logic               req_ready,
  output logic [31:0]        wr_data,
  output logic               wr_valid,
  output logic               wr_last,
  input  logic               wr_ready,
  output logic               rd_start,
  output logic [FRAME_W-1:0] frame_count,
  output logic [LINE_W-1:0]  line_count,
  output logic               fifo_full,
  output logic               fifo_empty
);
  localparam int DEPTH = 2 * PIXELS;

  logic [FRAME_W-1:0] frame_q;
  logic [LINE_W-1:0]  line_q;

  // Named internal events
  logic              frame_start, line_done;
  logic [LINE_W-1:0] line_idx_now;
  logic [31:0]       line_addr_now;
  logic              fifo_pop;
  logic [31:0]       fifo_data;

  assign frame_start   = pix_valid && pix_sof;
  assign line_done     = pix_valid && pix_eol;
  assign line_idx_now  = pix_sof ? '0 : line_q;
  assign line_addr_now = line_address(base_addr, 32'(line_idx_now), PIXELS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      line_q  <= '0;
    end else if (pix_valid) begin
      if (pix_sof) frame_q <= frame_q + 1'b1;
      if (pix_eol) line_q  <= line_idx_now + 1'b1;
      else if (pix_sof) line_q <= '0;
    end
  end

  assign frame_count = frame_q;
  assign line_count  = line_q;

  vlbw_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (pix_valid),
    .push_data (pad_pixel(pix_data)),
    .pop       (fifo_pop),
    .pop_data  (fifo_data),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  vlbw_burst_engine #(
    .PIXELS (PIXELS),
    .LINE_W (LINE_W),
    .LEN_W  (LEN_W),
    .TILE_H (TILE_H)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_done  (line_done),
    .line_idx   (line_idx_now),
    .line_addr  (line_addr_now),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .fifo_pop   (fifo_pop),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_ready  (req_ready),
    .wr_data    (wr_data),
    .wr_valid   (wr_valid),
    .wr_last    (wr_last),
    .wr_ready   (wr_ready),
    .rd_start   (rd_start)
  );

  // R7: a frame-start pixel also opens a line
  p_sof_sol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> pix_sol);
  // R7: the line counter stays inside the frame
  p_line_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= LINE_W'(LINES));
  // R7: the frame counter only moves on a frame start
  p_frame_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(frame_count));

endmodule

// File: tb/vid_line_burst_writer_bench.sv
`timescale 1ns/1ps
module vid_line_burst_writer_bench;
  localparam int PIX  = 4;
  localparam int LIN  = 4;
  localparam int TILE = 4;
  localparam int HALF = TILE / 2;
  localparam int LINE_W = $clog2(LIN + 1);
  localparam int LEN_W  = $clog2(PIX + 1);
  localparam logic [31:0] BASE = 32'h1000_0000;

  // Per frame: request grant delay, beat acceptance pattern, idle gap after each line
  localparam int unsigned VEC [3][3] = '{
    '{0, 0, 2},
    '{3, 1, 10},
    '{1, 2, 20}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] pix_data = '0;
  logic pix_valid = 1'b0, pix_sof = 1'b0, pix_sol = 1'b0, pix_eol = 1'b0;
  logic req_valid, req_ready, wr_valid, wr_last, wr_ready, rd_start;
  logic [31:0] req_addr, wr_data;
  logic [LEN_W-1:0] req_len;
  logic [15:0] frame_count;
  logic [LINE_W-1:0] line_count;
  logic fifo_full, fifo_empty;

  always #2 clk = ~clk;

  vid_line_burst_writer #(.PIXELS(PIX), .LINES(LIN), .TILE_H(TILE), .FRAME_W(16))
  u_vid_line_burst_writer (
    .clk(clk), .rst_n(rst_n), .base_addr(BASE),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_sol(pix_sol), .pix_eol(pix_eol),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_last(wr_last), .wr_ready(wr_ready),
    .rd_start(rd_start), .frame_count(frame_count), .line_count(line_count),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_pix [$];
  int exp_line [$];
  int req_delay = 0, wpat = 0, req_wait = 0, beat_idx = 0, cur_line = 0, cyc = 0;
  bit hold = 1'b0, rd_due = 1'b0;
  int rd_seen = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory-side responder and output monitor, all at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      req_ready = 1'b0; wr_ready = 1'b0; req_wait = 0; rd_due = 1'b0; beat_idx = 0;
    end else begin
      cyc++;
      if (rd_start || rd_due)
        chk(rd_start == rd_due, "R6 rd_start timing", 32'(rd_start), 32'(rd_due));
      if (rd_start) rd_seen++;
      rd_due = 1'b0;
      if (hold) begin
        req_ready = 1'b0; wr_ready = 1'b0;
      end else begin
        req_ready = (req_wait >= req_delay);
        case (wpat)
          0:       wr_ready = 1'b1;
          1:       wr_ready = cyc[0];
          default: wr_ready = (cyc % 3 == 0);
        endcase
      end
      if (req_valid && req_ready) begin
        req_wait = 0;
        if (exp_line.size() == 0) begin
          chk(1'b0, "R3 unexpected request", req_addr, 32'h0);
        end else begin
          cur_line = exp_line.pop_front();
          chk(req_addr == BASE + 32'(cur_line * PIX * 4), "R4 burst address", req_addr,
              BASE + 32'(cur_line * PIX * 4));
          chk(req_len == LEN_W'(PIX - 1), "R3 burst length", 32'(req_len), 32'(PIX - 1));
        end
      end else if (req_valid) begin
        req_wait++;
      end
      if (wr_valid && wr_ready) begin
        if (exp_pix.size() == 0) begin
          chk(1'b0, "R2 unexpected beat", wr_data, 32'h0);
        end else begin
          logic [31:0] ew;
          ew = {16'h0000, exp_pix.pop_front()};
          chk(wr_data == ew, "R2 beat data", wr_data, ew);
        end
        chk(wr_last == (beat_idx == PIX - 1), "R3 last flag", 32'(wr_last), 32'(beat_idx == PIX - 1));
        if (beat_idx == PIX - 1) begin
          beat_idx = 0;
          if (cur_line == HALF - 1) rd_due = 1'b1;
        end else begin
          beat_idx++;
        end
      end
    end
  end

  task automatic send_lines(input int f, input int nl, input int gap);
    for (int l = 0; l < nl; l++) begin
      for (int p = 0; p < PIX; p++) begin
        @(negedge clk);
        pix_valid = 1'b1;
        pix_data  = 16'(32'hA000 + f * 256 + l * 16 + p);
        pix_sof   = (l == 0 && p == 0);
        pix_sol   = (p == 0);
        pix_eol   = (p == PIX - 1);
        exp_pix.push_back(pix_data);
        if (p == PIX - 1) exp_line.push_back(l);
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        pix_valid = 1'b0; pix_data = 16'hDEAD;
        pix_sof = 1'b1; pix_sol = 1'b1; pix_eol = 1'b1;
      end
    end
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_sol = 1'b0; pix_eol = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_pix.size() != 0 || exp_line.size() != 0);
    repeat (4) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rd_before;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!req_valid, "R1 req_valid", 32'(req_valid), 32'h0);
    chk(!wr_valid, "R1 wr_valid", 32'(wr_valid), 32'h0);
    chk(!rd_start, "R1 rd_start", 32'(rd_start), 32'h0);
    chk(frame_count == 0, "R1 frame_count", 32'(frame_count), 32'h0);
    chk(line_count == 0, "R1 line_count", 32'(line_count), 32'h0);
    chk(fifo_empty && !fifo_full, "R1 fifo flags", {30'h0, fifo_full, fifo_empty}, 32'h1);
    rst_n = 1'b1;

    // Table of whole frames under different memory behaviour (R2-R7)
    for (int v = 0; v < 3; v++) begin
      req_delay = int'(VEC[v][0]);
      wpat      = int'(VEC[v][1]);
      rd_before = rd_seen;
      send_lines(v, LIN, int'(VEC[v][2]));
      wait_idle();
      chk(frame_count == 16'(v + 1), "R7 frame_count per frame", 32'(frame_count), 32'(v + 1));
      chk(line_count == LINE_W'(LIN), "R7 line_count at frame end", 32'(line_count), 32'(LIN));
      chk(rd_seen - rd_before == 1, "R6 one trigger per frame", 32'(rd_seen - rd_before), 32'h1);
      chk(fifo_empty, "R8 empty after drain", 32'(fifo_empty), 32'h1);
    end

    // R8: memory held off, two lines fill the buffer
    hold = 1'b1;
    req_delay = 0; wpat = 0;
    send_lines(3, 2, 0);
    repeat (2) @(negedge clk);
    chk(fifo_full, "R8 full after two stalled lines", 32'(fifo_full), 32'h1);
    chk(!fifo_empty, "R8 not empty while stalled", 32'(fifo_empty), 32'h0);
    chk(req_valid && req_addr == BASE, "R5 request held while stalled", req_addr, BASE);
    chk(line_count == 2, "R7 line_count mid frame", 32'(line_count), 32'h2);
    hold = 1'b0;
    wait_idle();
    chk(fifo_empty && !fifo_full, "R8 flags after release", {30'h0, fifo_full, fifo_empty}, 32'h1);

    // R4/R7: new frame after a partial one restarts the line index
    rd_before = rd_seen;
    send_lines(4, LIN, 3);
    wait_idle();
    chk(frame_count == 16'd5, "R7 frame_count after partial frame", 32'(frame_count), 32'h5);
    chk(rd_seen - rd_before == 1, "R6 trigger in frame after partial", 32'(rd_seen - rd_before), 32'h1);
    chk(!rd_start && !req_valid && !wr_valid, "R3 quiet when idle",
        {29'h0, rd_start, req_valid, wr_valid}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule